// File: doc/BRIEF.md
# Register Result-Latency Scoreboard

This block keeps, for each of a parameterised set of architectural registers, the number of cycles still to pass before the value being produced for it can be consumed. An in-order issue stage presents a candidate instruction each cycle: its operation class, its destination, its source registers and the role each source plays. The block answers with one ready flag per source. When the stage fires the instruction, the block records the producer class and a fresh wait count in the destination's entry.

Readiness is not one fixed latency per producer. It depends on the producer class, the consumer class and the operand role. Each entry stores the producer class next to a down-counter. At lookup time the counter is compared against a shortcut allowance, so the forwarding paths are modelled without storing one count per consumer. The data forwarding multiplexers themselves lie outside this block.

Top module: `reg_lat_scoreboard`

## Requirements
- R1: After a synchronous reset every entry is idle and `src_rdy` reads all ones.
- R2: A simple ALU (class 1) or shifted-operand ALU (class 2) result is usable 2 cycles after issue in general, but 1 cycle after issue by consumers of class 1, integer multiply (class 3) or integer multiply-accumulate (class 4).
- R3: For a shifted-operand ALU consumer (class 2) of an ALU result, the wait is 1 cycle for a source of role 0 (plain) or role 2 (accumulator), and 2 cycles for a source of role 1 (shift amount).
- R4: An integer multiply (class 3) or multiply-accumulate (class 4) result is usable after 2 cycles, or after 1 cycle when the consumer is class 4 and the source role is 2 (accumulator).
- R5: An integer divide (class 5) result is usable 5 cycles after issue for every consumer.
- R6: A one- or two-register integer load (class 6) result is usable after 2 cycles. A three- or four-register load (class 7) result is usable after 3 cycles.
- R7: A floating-point load (class 8) result is usable after 4 cycles, or after 2 cycles by floating-point arithmetic (class 9) and by the multiply-accumulate classes 10 and 11.
- R8: A floating-point arithmetic (class 9) result is usable after 4 cycles for every consumer.
- R9: A single-precision multiply-accumulate (class 10) result is usable after 8 cycles, or 4 cycles when a class-10 consumer reads it in role 2. A double-precision one (class 11) is usable after 11 cycles, or 7 cycles when a class-11 consumer reads it in role 2.
- R10: Classes 0 (no-op), 12 (store), 13 (branch) and the unused codes 14 and 15 write no entry: firing them leaves the destination's remaining wait unchanged, apart from its normal count-down.
- R11: Only a fired instruction (`issue_fire` = 1) writes its destination. The most recently fired writer of a register alone decides that register's readiness.
- R12: `src_rdy` is registered. In the cycle after a candidate is presented, it gives that candidate's readiness against the table as it stood before the candidate's own write.
- R13: A pending entry's wait falls by exactly one per cycle until it reaches zero and never exceeds 10. An idle source always reports ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_fire | input | 1 | The candidate issues this cycle and writes its destination |
| cand_cls | input | 4 | Candidate operation class (codes in R2 to R10) |
| cand_dst | input | IDX_W (4) | Candidate destination register |
| cand_src | input | NSRC*IDX_W (12) | Candidate source registers, source 0 in the low bits |
| cand_role | input | NSRC*2 (6) | Per-source role: 0 plain, 1 shift amount, 2 accumulator |
| src_rdy | output | NSRC (3) | Registered per-source ready flags |

## Verification
On every cycle the assertions check these behaviours: the all-ready state after reset, the exact wait loaded for divides, simple ALU ops and double-precision multiply-accumulates, the one-per-cycle drain and its upper bound, the rule that non-writing classes never raise an entry, and the rule that an idle source is always reported ready. The full producer, consumer and role matrix of shortcuts cannot be checked that way. Neither can the override of an older pending writer by a newer one, or the rule that an unfired candidate leaves no trace. Those are shown only by the bench scenarios, which compare each flag against an issue-cycle model.

// File: rtl/lat_sb_pkg.sv
package lat_sb_pkg;

  localparam int CLS_W  = 4;
  localparam int ROLE_W = 2;

  typedef enum logic [CLS_W-1:0] {
    K_NOP    = 4'd0,
    K_ALU    = 4'd1,
    K_ALUSH  = 4'd2,
    K_MUL    = 4'd3,
    K_MAC    = 4'd4,
    K_DIV    = 4'd5,
    K_LD12   = 4'd6,
    K_LD34   = 4'd7,
    K_FLD    = 4'd8,
    K_FOP    = 4'd9,
    K_FMACS  = 4'd10,
    K_FMACD  = 4'd11,
    K_STORE  = 4'd12,
    K_BRANCH = 4'd13
  } op_kind_e;

  typedef enum logic [ROLE_W-1:0] {
    ROLE_PLAIN = 2'd0,
    ROLE_SHAMT = 2'd1,
    ROLE_ACC   = 2'd2
  } src_role_e;

  // Nominal wait of a producer; zero means the class writes no register.
  function automatic int unsigned result_latency(op_kind_e k);
    case (k)
      K_ALU, K_ALUSH, K_MUL, K_MAC, K_LD12: return 2;
      K_LD34:                               return 3;
      K_FLD, K_FOP:                         return 4;
      K_DIV:                                return 5;
      K_FMACS:                              return 8;
      K_FMACD:                              return 11;
      default:                              return 0;
    endcase
  endfunction

  // Cycles a forwarding path removes from the nominal wait.
  function automatic int unsigned shortcut(op_kind_e prod, op_kind_e cons,
                                           src_role_e role);
    int unsigned cut;
    cut = 0;
    case (prod)
      K_ALU, K_ALUSH: begin
        if (cons == K_ALU || cons == K_MUL || cons == K_MAC) cut = 1;
        else if (cons == K_ALUSH && role != ROLE_SHAMT)      cut = 1;
      end
      K_MUL, K_MAC: begin
        if (cons == K_MAC && role == ROLE_ACC) cut = 1;
      end
      K_FLD: begin
        if (cons == K_FOP || cons == K_FMACS || cons == K_FMACD) cut = 2;
      end
      K_FMACS: begin
        if (cons == K_FMACS && role == ROLE_ACC) cut = 4;
      end
      K_FMACD: begin
        if (cons == K_FMACD && role == ROLE_ACC) cut = 4;
      end
      default: cut = 0;
    endcase
    return cut;
  endfunction

endpackage

// File: rtl/lat_sb_table.sv
module lat_sb_table
  import lat_sb_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int CNT_W = 5,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [CNT_W-1:0]                  wr_cnt,
  input  logic [CLS_W-1:0]                  wr_kind,
  output logic [NREG-1:0][CNT_W-1:0]        cnt_q,
  output logic [NREG-1:0][CLS_W-1:0]        kind_q
);

  // Every entry counts down in the same cycle, so the table lives in flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      kind_q <= '0;
    end else begin
      for (int e = 0; e < NREG; e++) begin
        if (wr_en && wr_idx == IDX_W'(e)) begin
          cnt_q[e]  <= wr_cnt;
          kind_q[e] <= wr_kind;
        end else if (cnt_q[e] != '0) begin
          cnt_q[e] <= cnt_q[e] - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lat_sb_lookup.sv
module lat_sb_lookup
  import lat_sb_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int CNT_W = 5,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0][CNT_W-1:0] cnt_tab,
  input  logic [NREG-1:0][CLS_W-1:0] kind_tab,
  input  logic [IDX_W-1:0]           src_idx,
  input  logic [ROLE_W-1:0]          src_role,
  input  logic [CLS_W-1:0]           cons_kind,
  output logic                       ready
);

  logic [CNT_W-1:0] pend;
  op_kind_e         prod;
  int unsigned      allow;

  always_comb begin
    pend  = cnt_tab[src_idx];
    prod  = op_kind_e'(kind_tab[src_idx]);
    allow = shortcut(prod, op_kind_e'(cons_kind), src_role_e'(src_role));
    ready = (32'(pend) <= allow);
  end

endmodule

// File: rtl/reg_lat_scoreboard.sv
module reg_lat_scoreboard
  import lat_sb_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int NSRC  = 3,
  parameter int CNT_W = 5,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue_fire,
  input  logic [CLS_W-1:0]        cand_cls,
  input  logic [IDX_W-1:0]        cand_dst,
  input  logic [NSRC*IDX_W-1:0]   cand_src,
  input  logic [NSRC*ROLE_W-1:0]  cand_role,
  output logic [NSRC-1:0]         src_rdy
);

  logic [NREG-1:0][CNT_W-1:0] cnt_tab;
  logic [NREG-1:0][CLS_W-1:0] kind_tab;
  logic                       wr_en;
  logic [CNT_W-1:0]           wr_cnt;
  logic [NSRC-1:0]            rdy_c;
  int unsigned                nom_lat;

  always_comb begin
    nom_lat = result_latency(op_kind_e'(cand_cls));
    wr_en   = issue_fire && (nom_lat != 0);
    wr_cnt  = (nom_lat != 0) ? CNT_W'(nom_lat - 1) : '0;
  end

  lat_sb_table #(
    .NREG  (NREG),
    .CNT_W (CNT_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (cand_dst),
    .wr_cnt  (wr_cnt),
    .wr_kind (cand_cls),
    .cnt_q   (cnt_tab),
    .kind_q  (kind_tab)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    lat_sb_lookup #(
      .NREG  (NREG),
      .CNT_W (CNT_W)
    ) u_lookup (
      .cnt_tab   (cnt_tab),
      .kind_tab  (kind_tab),
      .src_idx   (cand_src[s*IDX_W +: IDX_W]),
      .src_role  (cand_role[s*ROLE_W +: ROLE_W]),
      .cons_kind (cand_cls),
      .ready     (rdy_c[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) src_rdy <= '1;
    else     src_rdy <= rdy_c;
  end

endmodule

// File: rtl/lat_sb_checker.sv
module lat_sb_checker
  import lat_sb_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int NSRC  = 3,
  parameter int CNT_W = 5,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       issue_fire,
  input logic [CLS_W-1:0]           cand_cls,
  input logic [IDX_W-1:0]           cand_dst,
  input logic [NSRC*IDX_W-1:0]      cand_src,
  input logic [NSRC-1:0]            src_rdy,
  input logic [NREG-1:0][CNT_W-1:0] cnt_tab
);

  a_r1_reset_ready: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> src_rdy == '1);

  a_r2_alu_wait: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && op_kind_e'(cand_cls) == K_ALU)
      |=> cnt_tab[$past(cand_dst)] == CNT_W'(1));

  a_r5_div_wait: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && op_kind_e'(cand_cls) == K_DIV)
      |=> cnt_tab[$past(cand_dst)] == CNT_W'(4));

  a_r9_fmacd_wait: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && op_kind_e'(cand_cls) == K_FMACD)
      |=> cnt_tab[$past(cand_dst)] == CNT_W'(10));

  a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && (op_kind_e'(cand_cls) == K_NOP || op_kind_e'(cand_cls) == K_STORE
                    || op_kind_e'(cand_cls) == K_BRANCH || cand_cls >= 4'd14))
      |=> cnt_tab[$past(cand_dst)] <= $past(cnt_tab[cand_dst]));

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    a_r13_drain: assert property (@(posedge clk) disable iff (rst)
      (cnt_tab[g] != '0 && !(issue_fire && cand_dst == IDX_W'(g)))
        |=> cnt_tab[g] == CNT_W'($past(cnt_tab[g]) - 1'b1));

    a_r13_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_tab[g] <= CNT_W'(10));
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    a_r13_idle_ready: assert property (@(posedge clk) disable iff (rst)
      (cnt_tab[cand_src[s*IDX_W +: IDX_W]] == '0) |=> src_rdy[s]);
  end

endmodule

bind reg_lat_scoreboard lat_sb_checker #(
  .NREG  (NREG),
  .NSRC  (NSRC),
  .CNT_W (CNT_W)
) u_lat_sb_chk (
  .clk        (clk),
  .rst        (rst),
  .issue_fire (issue_fire),
  .cand_cls   (cand_cls),
  .cand_dst   (cand_dst),
  .cand_src   (cand_src),
  .src_rdy    (src_rdy),
  .cnt_tab    (cnt_tab)
);

// File: tb/reg_lat_scoreboard_tb.sv
module reg_lat_scoreboard_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_fire = 1'b0;
  logic [3:0]  cand_cls = '0;
  logic [3:0]  cand_dst = '0;
  logic [11:0] cand_src = '0;
  logic [5:0]  cand_role = '0;
  logic [2:0]  src_rdy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int last_t[16];
  int pk[16];

  always #5 clk = ~clk;

  reg_lat_scoreboard #(.NREG(16), .NSRC(3), .CNT_W(5)) u_dut (
    .clk (clk), .rst (rst), .issue_fire (issue_fire), .cand_cls (cand_cls),
    .cand_dst (cand_dst), .cand_src (cand_src), .cand_role (cand_role),
    .src_rdy (src_rdy)
  );

  // Effective wait in cycles from producer p to consumer c reading in role r.
  function automatic int eff_lat(int p, int c, int r);
    case (p)
      1, 2: begin
        if (c == 2) return (r == 1) ? 2 : 1;
        if (c == 1 || c == 3 || c == 4) return 1;
        return 2;
      end
      3, 4: return (c == 4 && r == 2) ? 1 : 2;
      5: return 5;
      6: return 2;
      7: return 3;
      8: return (c >= 9 && c <= 11) ? 2 : 4;
      9: return 4;
      10: return (c == 10 && r == 2) ? 4 : 8;
      11: return (c == 11 && r == 2) ? 7 : 11;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(int p, int c);
    case (p)
      1, 2: return (c == 2) ? "R3" : "R2";
      3, 4: return "R4";
      5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      9: return "R8";
      10, 11: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic step(bit f, int c, int d, int s0, int s1, int s2,
                      int r0, int r1, int r2, string tag);
    int  s[3];
    int  r[3];
    bit  e[3];
    string t[3];
    s = '{s0, s1, s2};
    r = '{r0, r1, r2};
    for (int i = 0; i < 3; i++) begin
      e[i] = (cyc - last_t[s[i]]) >= eff_lat(pk[s[i]], c, r[i]);
      t[i] = (tag == "") ? tag_for(pk[s[i]], c) : tag;
    end
    issue_fire = f;
    cand_cls   = 4'(c);
    cand_dst   = 4'(d);
    cand_src   = {4'(s2), 4'(s1), 4'(s0)};
    cand_role  = {2'(r2), 2'(r1), 2'(r0)};
    if (f && eff_lat(c, 0, 0) != 0) begin
      last_t[d] = cyc;
      pk[d]     = c;
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (src_rdy[i] !== e[i]) begin
        errors++;
        $display("FAIL %s cycle %0d src%0d: got %0b expected %0b", t[i], cyc, i,
                 src_rdy[i], e[i]);
      end
    end
    cyc++;
  endtask

  task automatic wait_q(int c, int reg_i, int role, int n, string tag);
    for (int k = 0; k < n; k++) step(0, c, 15, reg_i, reg_i, reg_i, role, 0, 2, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      last_t[i] = -1000;
      pk[i]     = 0;
    end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (src_rdy !== 3'b111) begin
      errors++;
      $display("FAIL R1 reset: got %b expected 111", src_rdy);
    end
    rst = 1'b0;

    // R12: own query sees the table before its own write
    step(1, 1, 1, 1, 1, 1, 0, 0, 0, "R12");
    // R3: shift-amount source waits the full two cycles
    step(0, 2, 15, 1, 1, 1, 1, 0, 2, "R3");
    step(0, 2, 15, 1, 1, 1, 1, 0, 2, "R3");
    // R2: ALU to multiply consumer
    step(1, 1, 2, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 3, 15, 2, 2, 2, 0, 1, 2, "R2");
    // R4: multiply to accumulator
    step(1, 3, 3, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 4, 15, 3, 3, 3, 2, 0, 1, "R4");
    step(0, 4, 15, 3, 3, 3, 2, 0, 1, "R4");
    // R5: divide
    step(1, 5, 4, 0, 0, 0, 0, 0, 0, "R5");
    wait_q(1, 4, 0, 5, "R5");
    // R6: loads
    step(1, 7, 5, 0, 0, 0, 0, 0, 0, "R6");
    wait_q(1, 5, 0, 3, "R6");
    step(1, 6, 5, 0, 0, 0, 0, 0, 0, "R6");
    wait_q(2, 5, 0, 2, "R6");
    // R7: fp load to fp arithmetic and to integer ALU
    step(1, 8, 6, 0, 0, 0, 0, 0, 0, "R7");
    wait_q(9, 6, 0, 2, "R7");
    step(1, 8, 6, 0, 0, 0, 0, 0, 0, "R7");
    wait_q(1, 6, 0, 4, "R7");
    // R8: fp arithmetic
    step(1, 9, 7, 0, 0, 0, 0, 0, 0, "R8");
    wait_q(10, 7, 2, 4, "R8");
    // R9: multiply-accumulate chains
    step(1, 10, 8, 0, 0, 0, 0, 0, 0, "R9");
    wait_q(10, 8, 2, 8, "R9");
    step(1, 11, 9, 0, 0, 0, 0, 0, 0, "R9");
    wait_q(11, 9, 2, 11, "R9");
    // R10: non-writing classes leave the destination alone
    step(1, 5, 10, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 12, 10, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 13, 10, 10, 10, 10, 0, 0, 0, "R10");
    wait_q(1, 10, 0, 4, "R10");
    step(1, 12, 11, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 1, 15, 11, 11, 11, 0, 0, 0, "R10");
    // R11: newer writer overrides, unfired candidate writes nothing
    step(1, 11, 12, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 1, 12, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 1, 15, 12, 12, 12, 0, 0, 0, "R11");
    step(0, 5, 13, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 1, 15, 13, 13, 13, 0, 0, 0, "R11");

    // Constrained random traffic on a small register window
    for (int n = 0; n < 3000; n++) begin
      step(($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 3)), "");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule